// File: doc/BRIEF.md
# Single-Wire Slave Transaction Sequencer

This block sits above the bit-level receiver of a single-wire bus slave. The bit-level logic has already turned line activity into two kinds of event: a strobe that marks a reset from the master, and whole received bytes, each with a valid strobe. The sequencer answers every reset with a request for a presence pulse. It then enforces the required order of a transaction: the reset, then exactly one ROM-level command byte, then a function command byte followed by any number of data bytes.

The ROM-level command decides whether this slave takes part in the function phase. The slave can be addressed directly by its 64-bit identifier, addressed unconditionally, asked to report its identifier, or handed to an external bit arbiter for a search. Any byte that breaks the order puts the slave into a silent state. It stays silent until the next bus reset. Only bytes that arrive in a legal function phase are passed downstream, and the first of them is marked as the command.

Top module: `owire_txn_seq`

## Requirements
- R1: One cycle after each `bus_reset` strobe, `presence_req` is high for exactly one cycle. This holds in every state, including partway through an identifier match.
- R2: After `rst`, the block ignores all bytes until the first `bus_reset`. It produces no forwarded byte, no identifier request and no selection.
- R3: ROM byte 0xCC selects the device at once. The first function-phase byte is forwarded with `func_is_cmd`=1. Later bytes are forwarded with `func_is_cmd`=0.
- R4: ROM byte 0x33 pulses `tx_id_req` for one cycle, with `tx_id_data` equal to `dev_id`. The transmitter sends it least significant bit first, so bits [7:0] go out first. The device is then selected.
- R5: ROM byte 0x55 takes the next 8 bytes as an identifier, least significant byte first, so byte k is compared with `dev_id[8k+7:8k]`. The device becomes selected only if all 8 bytes match. None of these 8 bytes is forwarded.
- R6: If any identifier byte differs, the block goes silent after the eighth byte. Every later byte is ignored until a `bus_reset`.
- R7: A ROM byte other than 0x33, 0x55, 0xCC, 0xF0 or 0xEC sends the block silent until a `bus_reset`.
- R8: ROM byte 0xF0 raises `search_active` and holds it until `search_done`. The block then waits for a reset and never selects the device or forwards bytes.
- R9: ROM byte 0xEC behaves like 0xF0 when `alarm_flag` is high. When `alarm_flag` is low, the block goes silent instead.
- R10: A `bus_reset` in any state drops the selection and any search. The next byte is then taken as a ROM command.
- R11: A forwarded byte appears on `func_byte`/`func_valid` one cycle after its `rx_valid`, and `func_valid` is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset | input | 1 | Strobe: master reset detected on the line |
| rx_byte | input | 8 | Received byte |
| rx_valid | input | 1 | Strobe: `rx_byte` is valid |
| alarm_flag | input | 1 | Device alarm condition is present |
| search_done | input | 1 | External search arbiter has finished |
| dev_id | input | 64 | Unique device identifier |
| presence_req | output | 1 | One-cycle request for a presence pulse |
| selected | output | 1 | Device is in the function phase |
| search_active | output | 1 | Search handed to external arbiter |
| tx_id_req | output | 1 | One-cycle request to transmit the identifier |
| tx_id_data | output | 64 | Identifier to transmit, LSB first |
| func_byte | output | 8 | Forwarded function-phase byte |
| func_valid | output | 1 | `func_byte` valid |
| func_is_cmd | output | 1 | Forwarded byte is the function command |

## Verification
The bench sends every one of the 256 possible ROM-slot bytes, with the alarm flag both high and low. A decoder with a wrong or missing code would select, search or forward on the wrong values. The identifier match is tried with a single flipped bit at each of the eight byte positions. A matcher that compared in the wrong byte order, or stopped early, would select a device it should not, or reject the right one. Resets are injected in the middle of a match and in the middle of a function phase. A sequencer that kept stale match progress or a stale selection would forward bytes that belong to no legal transaction.

// File: rtl/owseq_pkg.sv
package owseq_pkg;

    typedef enum logic [2:0] {
        ST_HALT,
        ST_ROM,
        ST_MATCH,
        ST_SEARCH,
        ST_FCMD,
        ST_FDATA
    } seq_state_t;

    typedef enum logic [2:0] {
        RC_NONE,
        RC_READ,
        RC_MATCH,
        RC_SKIP,
        RC_SEARCH,
        RC_ALARM
    } rom_cmd_t;

    typedef struct packed {
        logic       valid;
        logic       is_cmd;
        logic [7:0] data;
    } fwd_t;

    localparam logic [7:0] CODE_READ   = 8'h33;
    localparam logic [7:0] CODE_MATCH  = 8'h55;
    localparam logic [7:0] CODE_SKIP   = 8'hCC;
    localparam logic [7:0] CODE_SEARCH = 8'hF0;
    localparam logic [7:0] CODE_ALARM  = 8'hEC;

    function automatic rom_cmd_t classify(input logic [7:0] b);
        case (b)
            CODE_READ:   return RC_READ;
            CODE_MATCH:  return RC_MATCH;
            CODE_SKIP:   return RC_SKIP;
            CODE_SEARCH: return RC_SEARCH;
            CODE_ALARM:  return RC_ALARM;
            default:     return RC_NONE;
        endcase
    endfunction

endpackage

// File: rtl/owseq_rom_decode.sv
module owseq_rom_decode
    import owseq_pkg::*;
(
    input  logic [7:0] code,
    output rom_cmd_t   cmd
);
    always_comb cmd = classify(code);
endmodule

// File: rtl/owseq_id_match.sv
module owseq_id_match #(
    parameter  int ID_BYTES = 8,
    localparam int ID_W     = ID_BYTES * 8,
    localparam int CW       = $clog2(ID_BYTES)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            take,
    input  logic [7:0]      byte_in,
    input  logic [ID_W-1:0] id,
    output logic            last,
    output logic            all_ok
);
    logic [CW-1:0] idx;
    logic          bad;
    logic          byte_ok;

    always_comb begin
        byte_ok = (byte_in == id[int'(idx)*8 +: 8]);
        last    = (int'(idx) == ID_BYTES - 1);
        all_ok  = !bad && byte_ok;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            idx <= '0;
            bad <= 1'b0;
        end else if (take) begin
            idx <= idx + CW'(1);
            bad <= bad | !byte_ok;
        end
    end
endmodule

// File: rtl/owseq_fwd_reg.sv
module owseq_fwd_reg
    import owseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic       is_cmd,
    input  logic [7:0] data,
    output logic       func_valid,
    output logic       func_is_cmd,
    output logic [7:0] func_byte
);
    fwd_t q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.valid <= load;
            if (load) begin
                q.is_cmd <= is_cmd;
                q.data   <= data;
            end
        end
    end

    assign func_valid  = q.valid;
    assign func_is_cmd = q.is_cmd;
    assign func_byte   = q.data;
endmodule

// File: rtl/owire_txn_seq.sv
module owire_txn_seq
    import owseq_pkg::*;
#(
    parameter  int ID_BYTES = 8,
    localparam int ID_W     = ID_BYTES * 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_reset,
    input  logic [7:0]      rx_byte,
    input  logic            rx_valid,
    input  logic            alarm_flag,
    input  logic            search_done,
    input  logic [ID_W-1:0] dev_id,
    output logic            presence_req,
    output logic            selected,
    output logic            search_active,
    output logic            tx_id_req,
    output logic [ID_W-1:0] tx_id_data,
    output logic [7:0]      func_byte,
    output logic            func_valid,
    output logic            func_is_cmd
);
    seq_state_t state;
    rom_cmd_t   cmd;
    logic       m_last, m_ok, m_clear, m_take;
    logic       fwd_load;

    owseq_rom_decode u_dec (.code(rx_byte), .cmd(cmd));

    always_comb begin
        m_clear  = bus_reset || (state == ST_ROM && rx_valid && cmd == RC_MATCH);
        m_take   = !bus_reset && rx_valid && state == ST_MATCH;
        fwd_load = !bus_reset && rx_valid && (state == ST_FCMD || state == ST_FDATA);
    end

    owseq_id_match #(.ID_BYTES(ID_BYTES)) u_match (
        .clk(clk), .rst(rst), .clear(m_clear), .take(m_take),
        .byte_in(rx_byte), .id(dev_id), .last(m_last), .all_ok(m_ok)
    );

    owseq_fwd_reg u_fwd (
        .clk(clk), .rst(rst), .load(fwd_load), .is_cmd(state == ST_FCMD),
        .data(rx_byte), .func_valid(func_valid), .func_is_cmd(func_is_cmd),
        .func_byte(func_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_HALT;
            presence_req <= 1'b0;
            tx_id_req    <= 1'b0;
            tx_id_data   <= '0;
        end else begin
            presence_req <= bus_reset;
            tx_id_req    <= 1'b0;
            if (bus_reset) begin
                state <= ST_ROM;
            end else begin
                case (state)
                    ST_ROM: if (rx_valid) begin
                        case (cmd)
                            RC_READ: begin
                                tx_id_req  <= 1'b1;
                                tx_id_data <= dev_id;
                                state      <= ST_FCMD;
                            end
                            RC_MATCH:  state <= ST_MATCH;
                            RC_SKIP:   state <= ST_FCMD;
                            RC_SEARCH: state <= ST_SEARCH;
                            RC_ALARM:  state <= alarm_flag ? ST_SEARCH : ST_HALT;
                            default:   state <= ST_HALT;
                        endcase
                    end
                    ST_MATCH:  if (rx_valid && m_last) state <= m_ok ? ST_FCMD : ST_HALT;
                    ST_SEARCH: if (search_done) state <= ST_HALT;
                    ST_FCMD:   if (rx_valid) state <= ST_FDATA;
                    default: ;
                endcase
            end
        end
    end

    assign selected      = (state == ST_FCMD) || (state == ST_FDATA);
    assign search_active = (state == ST_SEARCH);
endmodule

// File: rtl/owseq_checks.sv
module owseq_checks (
    input logic clk,
    input logic rst,
    input logic bus_reset,
    input logic rx_valid,
    input logic search_done,
    input logic presence_req,
    input logic selected,
    input logic search_active,
    input logic tx_id_req,
    input logic func_valid
);
    assert_presence_follows_R1: assert property (@(posedge clk) disable iff (rst)
        bus_reset |=> presence_req);

    assert_presence_only_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        presence_req |-> $past(bus_reset));

    assert_fwd_needs_byte_R11: assert property (@(posedge clk) disable iff (rst)
        func_valid |-> $past(rx_valid));

    assert_fwd_when_selected_R3: assert property (@(posedge clk) disable iff (rst)
        func_valid |-> selected);

    assert_read_selects_R4: assert property (@(posedge clk) disable iff (rst)
        tx_id_req |-> selected);

    assert_search_holds_R8: assert property (@(posedge clk) disable iff (rst)
        search_active && !search_done && !bus_reset |=> search_active);

    assert_search_exits_R8: assert property (@(posedge clk) disable iff (rst)
        search_active && search_done && !bus_reset |=> !search_active && !selected);

    assert_no_fwd_in_search_R8: assert property (@(posedge clk) disable iff (rst)
        search_active |-> !func_valid);

    assert_reset_drops_R10: assert property (@(posedge clk) disable iff (rst)
        bus_reset |=> !selected && !search_active);
endmodule

bind owire_txn_seq owseq_checks u_chk (.*);

// File: tb/sim_owire_txn_seq.sv
`timescale 1ns/1ps
module sim_owire_txn_seq;
    localparam logic [63:0] ID = 64'h8E3D_5A21_C7F0_1B64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_reset = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        rx_valid = 1'b0;
    logic        alarm_flag = 1'b0;
    logic        search_done = 1'b0;
    logic        presence_req, selected, search_active, tx_id_req;
    logic [63:0] tx_id_data;
    logic [7:0]  func_byte;
    logic        func_valid, func_is_cmd;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    owire_txn_seq u0 (
        .clk(clk), .rst(rst), .bus_reset(bus_reset), .rx_byte(rx_byte),
        .rx_valid(rx_valid), .alarm_flag(alarm_flag), .search_done(search_done),
        .dev_id(ID), .presence_req(presence_req), .selected(selected),
        .search_active(search_active), .tx_id_req(tx_id_req),
        .tx_id_data(tx_id_data), .func_byte(func_byte), .func_valid(func_valid),
        .func_is_cmd(func_is_cmd)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse_reset();
        @(negedge clk) bus_reset = 1'b1;
        @(negedge clk) bus_reset = 1'b0;
        check(presence_req == 1'b1, "R1 presence after reset", presence_req, 1);
        check(selected == 1'b0 && search_active == 1'b0, "R10 reset drops state",
              {selected, search_active}, 0);
        @(negedge clk);
        check(presence_req == 1'b0, "R1 presence one cycle", presence_req, 0);
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk) begin rx_byte = b; rx_valid = 1'b1; end
        @(negedge clk) rx_valid = 1'b0;
    endtask

    task automatic finish_search();
        @(negedge clk) search_done = 1'b1;
        @(negedge clk) search_done = 1'b0;
        check(search_active == 1'b0, "R8 search ends on done", search_active, 0);
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(presence_req == 0 && selected == 0 && search_active == 0 && func_valid == 0 && tx_id_req == 0,
              "R2 reset state", {presence_req, selected, search_active, func_valid, tx_id_req}, 0);
        send(8'hCC);
        send(8'h33);
        check(tx_id_req == 0 && func_valid == 0 && selected == 0, "R2 ignored before bus reset",
              {tx_id_req, func_valid, selected}, 0);

        // Sweep every ROM-slot byte with both alarm flag values
        for (int af = 0; af < 2; af++) begin
            for (int code = 0; code < 256; code++) begin
                bit exp_srch, exp_fwd, exp_tx;
                alarm_flag = af[0];
                exp_tx   = (code == 8'h33);
                exp_srch = (code == 8'hF0) || (code == 8'hEC && af == 1);
                exp_fwd  = (code == 8'h33) || (code == 8'hCC);
                pulse_reset();
                send(code[7:0]);
                check(tx_id_req == exp_tx, "R4 read request", tx_id_req, exp_tx);
                if (exp_tx) check(tx_id_data == ID, "R4 id data", tx_id_data, ID);
                check(search_active == exp_srch, (code == 8'hEC) ? "R9 alarm search" : "R8 search",
                      search_active, exp_srch);
                send(8'h5A);
                check(func_valid == exp_fwd, exp_fwd ? "R3 forward cmd" : "R7 ignored byte",
                      func_valid, exp_fwd);
                check(selected == exp_fwd, "R7 selection", selected, exp_fwd);
                if (exp_fwd)
                    check(func_is_cmd == 1 && func_byte == 8'h5A, "R11 cmd byte",
                          {func_is_cmd, func_byte}, {1'b1, 8'h5A});
                if (exp_srch) begin
                    check(search_active == 1, "R8 search held", search_active, 1);
                    finish_search();
                    send(8'hCC);
                    send(8'h22);
                    check(func_valid == 0 && selected == 0, "R8 silent after search",
                          {func_valid, selected}, 0);
                end
            end
        end
        alarm_flag = 1'b0;

        // Identifier match, flipped bit at each position (pos 8: none)
        for (int pos = 0; pos < 9; pos++) begin
            bit exp_ok;
            exp_ok = (pos == 8);
            pulse_reset();
            send(8'h55);
            for (int k = 0; k < 8; k++) begin
                send(ID[k*8 +: 8] ^ ((k == pos) ? 8'h10 : 8'h00));
                check(func_valid == 0, "R5 id bytes not forwarded", func_valid, 0);
            end
            check(selected == exp_ok, exp_ok ? "R5 full match" : "R6 mismatch", selected, exp_ok);
            send(8'hC3);
            check(func_valid == exp_ok, "R6 after match", func_valid, exp_ok);
            if (exp_ok) begin
                check(func_is_cmd == 1 && func_byte == 8'hC3, "R3 first is cmd",
                      {func_is_cmd, func_byte}, {1'b1, 8'hC3});
                send(8'h11);
                check(func_valid == 1 && func_is_cmd == 0 && func_byte == 8'h11, "R3 data byte",
                      {func_valid, func_is_cmd, func_byte}, {1'b1, 1'b0, 8'h11});
                @(negedge clk);
                check(func_valid == 0, "R11 one cycle valid", func_valid, 0);
            end
        end

        // Byte order: reversed ID must fail
        pulse_reset();
        send(8'h55);
        for (int k = 7; k >= 0; k--) send(ID[k*8 +: 8]);
        check(selected == 0, "R5 byte order", selected, 0);

        // Reset in the middle of a match
        pulse_reset();
        send(8'h55);
        for (int k = 0; k < 3; k++) send(ID[k*8 +: 8]);
        pulse_reset();
        send(8'hCC);
        send(8'h77);
        check(func_valid == 1 && func_is_cmd == 1 && func_byte == 8'h77, "R10 restart mid match",
              {func_valid, func_is_cmd, func_byte}, {1'b1, 1'b1, 8'h77});

        // Reset in the middle of a function phase
        send(8'h01);
        pulse_reset();
        send(8'h44);
        send(8'hCC);
        send(8'h66);
        check(func_valid == 0 && selected == 0, "R10 next byte is rom cmd",
              {func_valid, selected}, 0);

        // Reset coinciding with a byte: reset wins
        pulse_reset();
        send(8'hCC);
        @(negedge clk) begin bus_reset = 1'b1; rx_byte = 8'h99; rx_valid = 1'b1; end
        @(negedge clk) begin bus_reset = 1'b0; rx_valid = 1'b0; end
        check(func_valid == 0 && presence_req == 1, "R10 reset beats byte",
              {func_valid, presence_req}, 2'b01);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule